// File: doc/BRIEF.md
# Period Timer with Prescaler and Postscaler

An 8-bit up-counter that advances on a divided tick-enable input, counts to a programmable period value and restarts from zero. The tick input is the instruction-rate enable (one quarter of the main oscillator). It first passes through a prescaler with ratios of 1, 4 or 16. Each time the count equals the period, a one-cycle match pulse is exported unscaled, so a PWM time base or a serial shift clock can use it.

The match pulse also drives a 4-bit postscaler. Every Nth match, with N from 1 to 16, sets a sticky interrupt flag. The interrupt output is that flag gated by an enable bit. Software reaches the count, period, control, flag and enable through a small register port: a synchronous write and a combinational read.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, the control reads 0x00, and the flag and enable read 0.
- R2: Control bits 1:0 select the prescale ratio: 2'b00 gives 1, 2'b01 gives 4, 2'b10 and 2'b11 give 16. While running, the count advances once per ratio ticks, where a tick is a cycle with `tick_i` high.
- R3: When an increment finds the count equal to the period, the count becomes 0x00 instead of count+1. In the cycle after that clock edge, `match_o` is high for one cycle, and the count then reads 0x00.
- R4: Control bits 6:3 hold K. The flag is set on every (K+1)th match counted since the last clear of the postscaler.
- R5: The flag is sticky. Writing a value with bit 0 clear to the flag register clears it. Writing bit 0 set has no effect. When a postscaler set and a clearing write happen in the same cycle, the flag ends up set.
- R6: `irq_o` is high exactly when both the flag and the enable bit (bit 0 of the enable register) are set.
- R7: Control bit 2 is the run enable. While it is clear, ticks are ignored and the count holds. Control bit 7 always reads 0.
- R8: A write to the count register or to the control register clears the prescaler and postscaler progress. The period register is left unchanged.
- R9: If the period is below the current count, the count keeps rising through 0xFF and wraps to 0x00 with no match. A match happens only on equality.
- R10: The register addresses are 0 for the count, 1 for the period, 2 for the control, 3 for the flag (bit 0) and 4 for the enable (bit 0). `rdata_o` shows the register selected by `addr_i` combinationally. Unused addresses and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-rate tick enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| match_o | output | 1 | Unscaled period-match pulse |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach is a clearing write to the flag that lands on the same edge as a postscaler terminal count. With a period of zero, a 1:1 prescaler and a 1:1 postscaler, every ticking cycle is a terminal count, so a clearing write issued with a tick must lose. The wrap past a lowered period is reached by writing a count above the period and running 236 ticks. Random traffic then mixes writes into running counts, and a cycle-accurate bench model is compared against the outputs on every cycle.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;
  typedef enum logic [2:0] {
    SEL_COUNT  = 3'd0,
    SEL_PERIOD = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_FLAG   = 3'd3,
    SEL_IEN    = 3'd4
  } reg_sel_e;

  localparam int unsigned PRE_SEL_W = 2;
  localparam int unsigned RUN_BIT   = 2;
  localparam int unsigned POST_LSB  = 3;
endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       inc_o
);
  localparam int unsigned PRE_W = 2 * STEP_LOG2;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;
  logic [1:0]       code;

  always_comb begin
    code = sel_i[1] ? 2'd2 : {1'b0, sel_i[0]};
    last = PRE_W'((32'd1 << (32'(code) * STEP_LOG2)) - 32'd1);
  end

  assign inc_o = tick_i && run_i && !clr_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && run_i)   cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  assert_pre_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;
  logic         match_q;

  assign hit_o   = inc_i && (cnt_q == period_i);
  assign cnt_o   = cnt_q;
  assign match_o = match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit_o;
      if (wr_i)       cnt_q <= wdata_i;
      else if (inc_i) cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
    end
  end

  assert_hold_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> (cnt_o == $past(cnt_o)));
  assert_match_restarts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (cnt_o == '0));
  assert_wrap_past_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && (cnt_o == '1) && (period_i != '1)) |=> ((cnt_o == '0) && !match_o));
endmodule

// File: rtl/pt_postscaler.sv
module pt_postscaler #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hit_i,
  input  logic [W-1:0] ratio_i,
  output logic         fire_o
);
  logic [W-1:0] cnt_q;

  assign fire_o = hit_i && (cnt_q == ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (hit_i)  cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
  end

  assert_post_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ratio_i);
endmodule

// File: rtl/period_timer.sv
module period_timer
  import period_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned POST_W    = 4,
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             match_o,
  output logic             irq_o
);
  localparam int unsigned CTRL_W = POST_LSB + POST_W;

  reg_sel_e           sel;
  logic [CNT_W-1:0]   period_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               flag_q, ien_q;
  logic [CNT_W-1:0]   cnt;
  logic               wr_cnt, wr_per, wr_ctrl, wr_flag, wr_ien, clr;
  logic               inc, hit, fire;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_cnt  = we_i && (sel == SEL_COUNT);
  assign wr_per  = we_i && (sel == SEL_PERIOD);
  assign wr_ctrl = we_i && (sel == SEL_CTRL);
  assign wr_flag = we_i && (sel == SEL_FLAG);
  assign wr_ien  = we_i && (sel == SEL_IEN);
  assign clr     = wr_cnt || wr_ctrl;

  pt_prescaler #(.STEP_LOG2(STEP_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (ctrl_q[RUN_BIT]),
    .tick_i (tick_i),
    .sel_i  (ctrl_q[PRE_SEL_W-1:0]),
    .inc_o  (inc)
  );

  pt_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc),
    .wr_i     (wr_cnt),
    .wdata_i  (wdata_i),
    .period_i (period_q),
    .cnt_o    (cnt),
    .hit_o    (hit),
    .match_o  (match_o)
  );

  pt_postscaler #(.W(POST_W)) u_post (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .hit_i   (hit),
    .ratio_i (ctrl_q[POST_LSB +: POST_W]),
    .fire_o  (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      if (wr_per)  period_q <= wdata_i;
      if (wr_ctrl) ctrl_q   <= wdata_i[CTRL_W-1:0];
      if (wr_ien)  ien_q    <= wdata_i[0];
      // hardware set beats software clear
      if (fire)                         flag_q <= 1'b1;
      else if (wr_flag && !wdata_i[0])  flag_q <= 1'b0;
    end
  end

  assign irq_o = flag_q && ien_q;

  always_comb begin
    unique case (sel)
      SEL_COUNT:  rdata_o = cnt;
      SEL_PERIOD: rdata_o = period_q;
      SEL_CTRL:   rdata_o = CNT_W'(ctrl_q);
      SEL_FLAG:   rdata_o = CNT_W'(flag_q);
      SEL_IEN:    rdata_o = CNT_W'(ien_q);
      default:    rdata_o = '0;
    endcase
  end

  assert_flag_rise_from_post_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(fire));
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> flag_q);
  assert_period_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_per |=> (period_q == $past(period_q)));
  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_q && !wr_ien) |=> !irq_o);
endmodule

// File: tb/period_timer_bench.sv
`timescale 1ns/1ps
module period_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata_o;
  logic       match_o, irq_o;

  int tests = 0, fails = 0, nmatch = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  period_timer u_period_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .match_o(match_o), .irq_o(irq_o)
  );

  // reference model
  logic [7:0] m_cnt, m_per;
  logic [6:0] m_ctl;
  logic       m_flag, m_ie, m_match;
  int         m_pre;
  logic [3:0] m_post;

  function automatic int ratio(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 4 : 16;
  endfunction

  function automatic logic [7:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_per;
      3'd2: return {1'b0, m_ctl};
      3'd3: return {7'd0, m_flag};
      3'd4: return {7'd0, m_ie};
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic clr, inc, hit, fire;
    int last;
    if (!rst_n) begin
      m_cnt <= 8'h00; m_per <= 8'hFF; m_ctl <= 7'h00; m_flag <= 1'b0;
      m_ie <= 1'b0; m_match <= 1'b0; m_pre <= 0; m_post <= 4'd0;
    end else begin
      clr  = we && (addr == 3'd0 || addr == 3'd2);
      last = ratio(m_ctl[1:0]) - 1;
      inc  = tick && m_ctl[2] && !clr && (m_pre == last);
      hit  = inc && (m_cnt == m_per);
      fire = 1'b0;
      if (clr) m_pre <= 0;
      else if (tick && m_ctl[2]) m_pre <= (m_pre == last) ? 0 : m_pre + 1;
      if (we && addr == 3'd0) m_cnt <= wdata;
      else if (inc) m_cnt <= hit ? 8'h00 : m_cnt + 8'd1;
      m_match <= hit;
      if (clr) m_post <= 4'd0;
      else if (hit) begin
        if (m_post == m_ctl[6:3]) begin m_post <= 4'd0; fire = 1'b1; end
        else m_post <= m_post + 4'd1;
      end
      if (fire) m_flag <= 1'b1;
      else if (we && addr == 3'd3 && !wdata[0]) m_flag <= 1'b0;
      if (we && addr == 3'd4) m_ie <= wdata[0];
      if (we && addr == 3'd1) m_per <= wdata;
      if (we && addr == 3'd2) m_ctl <= wdata[6:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    if (match_o === 1'b1) nmatch++;
    chk(match_o === m_match, "R3 match pulse", 32'(match_o), 32'(m_match));
    chk(irq_o === (m_flag & m_ie), "R6 irq gate", 32'(irq_o), 32'(m_flag & m_ie));
    tick = t; we = w; addr = a; wdata = d;
    #1;
    chk(rdata_o === mread(a), "R10 read data", 32'(rdata_o), 32'(mread(a)));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b0, 1'b0, a, 8'd0);
    chk(rdata_o === exp, tag, 32'(rdata_o), 32'(exp));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd0, 8'h00, "R1 count");
    rd(3'd1, 8'hFF, "R1 period");
    rd(3'd2, 8'h00, "R1 control");
    rd(3'd3, 8'h00, "R1 flag");
    rd(3'd4, 8'h00, "R1 enable");
    rd(3'd6, 8'h00, "R10 unused address");

    // R7 bit 7 reads zero, stopped counter holds
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'h7F, "R7 control bit7");
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h33);
    ticks(20);
    rd(3'd0, 8'h33, "R7 stopped hold");

    // R2 prescale ratios
    wr(3'd2, 8'h05); wr(3'd0, 8'h00); ticks(8);
    rd(3'd0, 8'h02, "R2 ratio 4");
    wr(3'd2, 8'h06); wr(3'd0, 8'h00); ticks(32);
    rd(3'd0, 8'h02, "R2 ratio 16 code2");
    wr(3'd2, 8'h07); wr(3'd0, 8'h00); ticks(32);
    rd(3'd0, 8'h02, "R2 ratio 16 code3");
    wr(3'd2, 8'h04); wr(3'd0, 8'h00); ticks(5);
    rd(3'd0, 8'h05, "R2 ratio 1");

    // R3 period restart with 1:4
    wr(3'd1, 8'h03); wr(3'd2, 8'h05); wr(3'd0, 8'h00);
    nmatch = 0; ticks(40);
    chk(nmatch == 2, "R3 match count", 32'(nmatch), 32'd2);

    // R8 count write clears prescaler, period kept
    wr(3'd1, 8'hFF); wr(3'd2, 8'h05); wr(3'd0, 8'h00);
    ticks(3); wr(3'd0, 8'h40); ticks(3);
    rd(3'd0, 8'h40, "R8 prescaler cleared");
    ticks(1);
    rd(3'd0, 8'h41, "R8 advance after clear");
    rd(3'd1, 8'hFF, "R8 period kept");

    // R4 postscaler 1:3, R6 irq
    wr(3'd4, 8'h01); wr(3'd1, 8'h01); wr(3'd2, 8'h14); wr(3'd0, 8'h00); wr(3'd3, 8'h00);
    ticks(5);
    rd(3'd3, 8'h00, "R4 before third match");
    ticks(1);
    rd(3'd3, 8'h01, "R4 third match sets flag");
    chk(irq_o === 1'b1, "R6 irq asserted", 32'(irq_o), 32'd1);
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h00, "R6 enable cleared");
    chk(irq_o === 1'b0, "R6 irq masked", 32'(irq_o), 32'd0);

    // R5 clear, write-one ignored, set wins
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    rd(3'd3, 8'h00, "R5 clear by zero");
    wr(3'd3, 8'h01);
    rd(3'd3, 8'h00, "R5 write one ignored");
    wr(3'd1, 8'h00); wr(3'd2, 8'h04); wr(3'd0, 8'h00);
    ticks(2);
    cyc(1'b1, 1'b1, 3'd3, 8'h00);
    rd(3'd3, 8'h01, "R5 set wins over clear");

    // R9 period below count wraps
    wr(3'd1, 8'h0A); wr(3'd2, 8'h04); wr(3'd0, 8'h14);
    nmatch = 0; ticks(236);
    rd(3'd0, 8'h00, "R9 wrapped to zero");
    chk(nmatch == 0, "R9 no match before wrap", 32'(nmatch), 32'd0);
    ticks(11);
    rd(3'd0, 8'h00, "R9 restart at period");
    chk(nmatch == 1, "R9 match on equality", 32'(nmatch), 32'd1);

    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      logic       w;
      logic [2:0] a;
      logic [7:0] d;
      w = ($urandom % 16) == 0;
      a = 3'($urandom % 6);
      d = 8'($urandom);
      if (a == 3'd1) d = d & 8'h1F;
      if (a == 3'd2) d = d | 8'h04;
      cyc(($urandom % 4) != 0, w, a, d);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule